// File: doc/BRIEF.md
# PWM Output Steering Unit

This block takes a single PWM waveform and distributes it over four output pins, named A, B, C and D. Each pin either carries the PWM, shaped by a per-pin-group polarity, or falls back to a general-purpose port bit supplied by the surrounding logic. A 2-bit pair field can override the per-pin enables and form a complementary pair, in which pin A carries the PWM and one partner pin carries its exact inverse.

Software programs the unit through one 8-bit control register with a byte write and a combinational read. A sync bit in the written value chooses when the new setting takes effect. With the bit clear, it applies on the clock edge of the write. With the bit set, it waits in a shadow copy until the edge on which the period-start strobe is high. Steering applies only while the mode inputs select PWM operation with a single-output configuration. In every other mode, the pins mirror the port bits.

Top module: `pwm_steer_top`

## Requirements
- R1: After reset, the control register reads 0x01 and no update is pending. With steering active, pin A carries the PWM and pins B, C and D carry their port bits.
- R2: Control bit 5 always reads 0, and writing it has no effect on the stored value or on the pins.
- R3: With pair field (bits 7:6) equal to 00, a pin whose enable bit is 1 (bit 0 = A, 1 = B, 2 = C, 3 = D) carries the PWM XOR its polarity bit, and a pin whose enable bit is 0 carries its port bit.
- R4: Polarity input bit 0 inverts the PWM on pins A and C when 1. Polarity input bit 1 does the same for pins B and D, independently of bit 0.
- R5: Pair field 01 pairs A with B, 10 pairs A with C, and 11 pairs A with D. Pin A carries the PWM at A's polarity, the partner carries the inverse of pin A, and the two remaining pins carry their port bits.
- R6: A write with sync bit (bit 4) equal to 0 changes the pins from the clock edge that samples the write.
- R7: A write with sync bit 1 leaves the pins unchanged until a clock edge where period_start is 1, and applies at that edge.
- R8: A second write made before the period boundary replaces the pending value. Only the last written value is applied.
- R9: Reads return the most recently written value, even while that value is still pending.
- R10: Steering applies only when pwm_mode is 1 and out_cfg is 00. Otherwise all four pins equal port_data.
- R11: A write with sync bit 1 in the same cycle as period_start takes effect at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value (last written) |
| pwm_in | input | 1 | PWM waveform to steer |
| period_start | input | 1 | High for the cycle that starts a PWM period |
| pwm_mode | input | 1 | 1 when the capture/compare unit is in PWM mode |
| out_cfg | input | 2 | Output configuration, 00 = single output |
| polarity | input | 2 | Bit 0 inverts A/C, bit 1 inverts B/D |
| port_data | input | 4 | Port fallback values, bit 0 = A |
| pins | output | 4 | Steered pin values, bit 0 = A |

## Verification
A register write and a period-start strobe can land on the same clock edge. In that case the new value must be applied at that edge, and an older pending value must not be applied. The bench provokes this in two ways. It raises period_start in the very cycle of a deferred write. It also strobes the boundary after two back-to-back deferred writes. In both cases it judges the pins one cycle later against a value computed from the last write alone. The full sweep of the control byte, polarity, PWM level, port bits and modes checks the routing arithmetic separately.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int CTRL_W  = 8;
  localparam int PIN_N   = 4;
  localparam int SYNC_B  = 4;
  localparam int UNUSED_B = 5;
  localparam int PAIR_LO = 6;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 8'h01;
  localparam logic [CTRL_W-1:0] CTRL_MASK = ~(8'h01 << UNUSED_B);

  // Pin i of the steered output; polarity bit (i % 2) applies
  function automatic logic [PIN_N-1:0] route_pins(
    input logic [CTRL_W-1:0] ctrl,
    input logic              pwm,
    input logic [1:0]        pol,
    input logic [PIN_N-1:0]  port,
    input logic              on
  );
    logic [PIN_N-1:0] drv;
    logic [1:0]       pr;
    logic [PIN_N-1:0] res;
    for (int i = 0; i < PIN_N; i++) drv[i] = pwm ^ pol[i % 2];
    pr  = ctrl[PAIR_LO +: 2];
    res = port;
    if (on) begin
      if (pr == 2'b00) begin
        for (int i = 0; i < PIN_N; i++) res[i] = ctrl[i] ? drv[i] : port[i];
      end else begin
        res[0]  = drv[0];
        res[pr] = ~drv[0];
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/pst_regs.sv
module pst_regs
  import pst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              period_start,
  output logic [CTRL_W-1:0] rd_data,
  output logic [CTRL_W-1:0] act_ctrl,
  output logic              pending
);
  logic [CTRL_W-1:0] wr_q, act_q, wr_clean;
  logic              pend_q;
  logic              apply_now, apply_shadow;

  assign wr_clean     = wr_data & CTRL_MASK;
  assign apply_now    = wr_en && (!wr_data[SYNC_B] || period_start);
  assign apply_shadow = !wr_en && pend_q && period_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= CTRL_RST;
      act_q  <= CTRL_RST;
      pend_q <= 1'b0;
    end else begin
      if (wr_en) wr_q <= wr_clean;
      if (apply_now) begin
        act_q  <= wr_clean;
        pend_q <= 1'b0;
      end else if (wr_en) begin
        pend_q <= 1'b1;
      end else if (apply_shadow) begin
        act_q  <= wr_q;
        pend_q <= 1'b0;
      end
    end
  end

  assign rd_data  = wr_q;
  assign act_ctrl = act_q;
  assign pending  = pend_q;

  a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & CTRL_MASK));
  a_r2_bit5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[UNUSED_B] == 1'b0);
  a_r6_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[SYNC_B]) |=> act_ctrl == ($past(wr_data) & CTRL_MASK));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !period_start) |=> $stable(act_ctrl));
  a_r7_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !wr_en && period_start) |=> act_ctrl == $past(rd_data));
  a_r11_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[SYNC_B] && period_start) |=> (act_ctrl == rd_data && !pending));
endmodule

// File: rtl/pst_mode_gate.sv
module pst_mode_gate (
  input  logic       pwm_mode,
  input  logic [1:0] out_cfg,
  output logic       steer_on
);
  localparam logic [1:0] CFG_SINGLE = 2'b00;
  assign steer_on = pwm_mode && (out_cfg == CFG_SINGLE);
endmodule

// File: rtl/pst_route.sv
module pst_route
  import pst_pkg::*;
(
  input  logic [CTRL_W-1:0] act_ctrl,
  input  logic              pwm_in,
  input  logic [1:0]        polarity,
  input  logic [PIN_N-1:0]  port_data,
  input  logic              steer_on,
  output logic [PIN_N-1:0]  pins
);
  logic [1:0] pair_sel;
  assign pair_sel = act_ctrl[PAIR_LO +: 2];
  assign pins = route_pins(act_ctrl, pwm_in, polarity, port_data, steer_on);

  always_comb begin
    if (!steer_on) a_r10_port_only: assert (pins == port_data);
    if (steer_on && pair_sel != 2'b00) a_r5_complement: assert (pins[0] != pins[pair_sel]);
    if (steer_on) a_r4_pin_a: assert (pins[0] == (act_ctrl[0] || pair_sel != 2'b00 ? (pwm_in ^ polarity[0]) : port_data[0]));
  end
endmodule

// File: rtl/pwm_steer_top.sv
module pwm_steer_top
  import pst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       pwm_in,
  input  logic       period_start,
  input  logic       pwm_mode,
  input  logic [1:0] out_cfg,
  input  logic [1:0] polarity,
  input  logic [3:0] port_data,
  output logic [3:0] pins
);
  logic [CTRL_W-1:0] act_ctrl;
  logic              pending;
  logic              steer_on;

  pst_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .period_start(period_start), .rd_data(rd_data),
    .act_ctrl(act_ctrl), .pending(pending)
  );

  pst_mode_gate u_gate (
    .pwm_mode(pwm_mode), .out_cfg(out_cfg), .steer_on(steer_on)
  );

  pst_route u_route (
    .act_ctrl(act_ctrl), .pwm_in(pwm_in), .polarity(polarity),
    .port_data(port_data), .steer_on(steer_on), .pins(pins)
  );

  a_r1_no_pending_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (pending |-> $past(wr_en) || $past(pending)));
endmodule

// File: tb/sim_pwm_steer_top.sv
`timescale 1ns/1ps
module sim_pwm_steer_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       pwm_in = 0;
  logic       period_start = 0;
  logic       pwm_mode = 1;
  logic [1:0] out_cfg = 0;
  logic [1:0] polarity = 0;
  logic [3:0] port_data = 0;
  logic [3:0] pins;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  pwm_steer_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pwm_in(pwm_in), .period_start(period_start), .pwm_mode(pwm_mode),
    .out_cfg(out_cfg), .polarity(polarity), .port_data(port_data), .pins(pins)
  );

  // Independent model: per pin choose source by a case on the pair field
  function automatic logic [3:0] model(input logic [7:0] c, input logic p,
      input logic [1:0] pl, input logic [3:0] pt, input logic md, input logic [1:0] cf);
    logic [3:0] r;
    logic a;
    r = pt;
    if (md == 1'b1 && cf == 2'b00) begin
      a = pl[0] ? ~p : p;
      case (c[7:6])
        2'd0: begin
          if (c[0]) r[0] = a;
          if (c[1]) r[1] = pl[1] ? ~p : p;
          if (c[2]) r[2] = a;
          if (c[3]) r[3] = pl[1] ? ~p : p;
        end
        2'd1: begin r[0] = a; r[1] = !a; end
        2'd2: begin r[0] = a; r[2] = !a; end
        default: begin r[0] = a; r[3] = !a; end
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic ps);
    @(negedge clk);
    wr_en = 1; wr_data = d; period_start = ps;
    @(negedge clk);
    wr_en = 0; period_start = 0;
  endtask

  task automatic strobe();
    @(negedge clk); period_start = 1;
    @(negedge clk); period_start = 0;
  endtask

  initial begin
    #(4.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd", rd_data, 8'h01);
    pwm_in = 1; port_data = 4'b0100; #0.5;
    chk("R1 pins", {4'h0, pins}, 8'h05);

    // R2 bit5 ignored
    wr(8'h21, 0);
    chk("R2 rd", rd_data, 8'h01);
    chk("R2 pins", {4'h0, pins}, {4'h0, model(8'h01, 1, 0, 4'b0100, 1, 0)});

    // R3/R4/R5 sweep over control byte (sync 0), pwm, polarity, port
    for (int c = 0; c < 256; c++) begin
      if (c[4] || c[5]) continue;
      wr(c[7:0], 0);
      chk("R6 rd", rd_data, c[7:0]);
      for (int v = 0; v < 128; v++) begin
        pwm_in = v[0]; polarity = v[2:1]; port_data = v[6:3];
        #0.25;
        chk(c[7:6] == 0 ? "R3/R4 route" : "R5 pair", {4'h0, pins},
            {4'h0, model(c[7:0], v[0], v[2:1], v[6:3], 1, 0)});
      end
    end

    // R10 mode gating
    wr(8'h4F, 0);
    for (int m = 0; m < 8; m++) begin
      for (int v = 0; v < 32; v++) begin
        pwm_mode = m[0]; out_cfg = m[2:1];
        pwm_in = v[0]; port_data = v[4:1]; polarity = 2'b01;
        #0.25;
        chk("R10 mode", {4'h0, pins}, {4'h0, model(8'h4F, v[0], 2'b01, v[4:1], m[0], m[2:1])});
      end
    end
    pwm_mode = 1; out_cfg = 0; polarity = 0; pwm_in = 1; port_data = 0;

    // R6 immediate
    wr(8'h0F, 0);
    chk("R6 pins", {4'h0, pins}, 8'h0F);
    // R7/R9 deferred
    wr(8'h12, 0);
    chk("R9 pending rd", rd_data, 8'h12);
    chk("R7 held", {4'h0, pins}, 8'h0F);
    repeat (5) @(negedge clk);
    chk("R7 still held", {4'h0, pins}, 8'h0F);
    // R8 overwrite
    wr(8'h14, 0);
    chk("R8 rd", rd_data, 8'h14);
    chk("R8 held", {4'h0, pins}, 8'h0F);
    strobe();
    chk("R8 applied", {4'h0, pins}, 8'h04);
    // R7 strobe with nothing pending changes nothing
    strobe();
    chk("R7 idle strobe", {4'h0, pins}, 8'h04);
    // R11 same-cycle write and strobe
    wr(8'h18, 1);
    chk("R11 same edge", {4'h0, pins}, 8'h08);
    // R11 pending then write+strobe: older pending not applied
    wr(8'h11, 0);
    wr(8'hD0, 1);
    chk("R11 pair D", {4'h0, pins}, 8'h01);
    chk("R11 rd", rd_data, 8'hD0);
    strobe();
    chk("R11 stays", {4'h0, pins}, 8'h01);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule